// File: doc/BRIEF.md
# Execution trace PC reconstructor

This block takes the trace words a small processor core emits as it retires instructions and rebuilds the program counter each word belongs to. A trace word is 36 bits wide. Bit 35 says an interrupt handler is running. Bit 33 marks a load/store effective address. Bit 32 marks a control-transfer target. Bits 31:0 hold the payload. Bit 34 is not used. A word with neither bit 32 nor bit 33 set carries a register result.

While the block knows the PC, it fetches the opcode at that PC through a request/response instruction-memory port. It checks that the entry kind fits the instruction class, then moves the tracked PC on by the instruction length or to the branch target. While the PC is unknown, entries pass through unresolved until a branch entry or an interrupt entry restores tracking. Every accepted word produces exactly one output beat, so a downstream consumer can annotate the stream.

Top module: `trace_pc_rebuild`

## Requirements
- R1: After reset the block is unsynchronised. `in_ready` is 1, `imem_req` is 0 and `out_valid` is 0.
- R2: While unsynchronised, a non-branch entry makes no instruction-memory request. Its beat has `out_synced`=0, `out_pc`=0 and no error flags, and the block stays unsynchronised.
- R3: While unsynchronised, a branch entry gives an unsynchronised beat and sets the tracked PC to the payload with bit 0 cleared. The next entry is then tracked.
- R4: While synchronised, an entry drives `imem_req`=1 with `imem_addr` equal to the tracked PC and holds both until `imem_rsp_valid`. `in_ready` is 0 for as long as the request is pending. The beat reports that PC with `out_synced`=1.
- R5: After a result entry with an instruction hit, the PC advances by 4 when opcode bits [1:0] are 2'b11, and by 2 otherwise.
- R6: An address entry leaves the tracked PC unchanged.
- R7: After a synchronised branch entry, the tracked PC becomes the payload with bit 0 cleared.
- R8: When the interrupt bit is 1 on an entry and was 0 on the previous accepted entry, the PC is forced to 0x10 and the block becomes synchronised before that entry is handled. An interrupt bit that stays at 1, or falls to 0, forces nothing.
- R9: A branch entry raises `out_class_err` unless its instruction is a control transfer. The control transfers are: major opcodes 7'h6f, 7'h67 and 7'h63; major opcode 7'h0b with bits [31:25]=7'h02 (interrupt return); and the compressed forms quadrant 01 with funct3 001, 101, 110 or 111, and quadrant 10 with funct3 100, bits [6:2]=0 and bits [11:7]≠0.
- R10: An address entry raises `out_class_err` unless its instruction is a load or store. The loads and stores are major opcodes 7'h03 and 7'h23, and quadrants 00 and 10 with funct3 010 or 110.
- R11: When `imem_hit`=0, the beat has `out_miss`=1 and `out_class_err`=0. The block becomes unsynchronised, except that a branch entry still loads its payload and stays synchronised.
- R12: `out_kind` is 2'b10 for a branch entry, 2'b01 for an address entry and 2'b00 for a result entry. Bit 32 takes priority over bit 33. `out_irq` copies bit 35.
- R13: Each accepted word yields exactly one `out_valid` beat, in order. The beat comes one cycle after acceptance when no lookup is made, and one cycle after the response otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Trace word present |
| in_ready | output | 1 | Block can accept a trace word |
| in_word | input | 36 | Trace word |
| imem_req | output | 1 | Opcode lookup pending |
| imem_addr | output | 32 | Address of the lookup |
| imem_rsp_valid | input | 1 | Lookup response present |
| imem_hit | input | 1 | An instruction exists at the address |
| imem_insn | input | 32 | Opcode returned by the lookup |
| out_valid | output | 1 | Output beat strobe |
| out_pc | output | 32 | PC of the instruction the entry belongs to |
| out_kind | output | 2 | Entry kind |
| out_irq | output | 1 | Interrupt bit of the entry |
| out_synced | output | 1 | `out_pc` is meaningful |
| out_class_err | output | 1 | Entry kind does not fit the instruction class |
| out_miss | output | 1 | No instruction at the tracked PC |

## Verification
Some rules are checked on every cycle: the lookup handshake (stall while a request is pending, stable address), the fact that every beat follows an acceptance or a response, the exclusivity of the miss and class-error flags, and the flag-free form of unsynchronised beats. The PC arithmetic can only be shown by the bench's scenarios against a behavioural model. This covers the step of 2 or 4, holding on address entries, branch reloads with bit 0 masking, forcing on an interrupt edge, resynchronisation after a miss and the class decode. These scenarios run with zero and nonzero lookup latency.

// File: rtl/trace_pc_rebuild_pkg.sv
`timescale 1ns/1ps
package trace_pc_rebuild_pkg;
  typedef enum logic [1:0] {
    KIND_RESULT = 2'b00,
    KIND_ADDR   = 2'b01,
    KIND_BRANCH = 2'b10
  } entry_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tpr_insn_class.sv
`timescale 1ns/1ps
// Classifies an opcode as control transfer or memory access, and gives its length.
module tpr_insn_class #(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] insn,
  output logic            is_flow,
  output logic            is_mem,
  output logic            is_full
);
  logic [6:0] major;
  logic [2:0] c_f3;

  always_comb begin
    major   = insn[6:0];
    c_f3    = insn[15:13];
    is_full = (insn[1:0] == 2'b11);
    is_flow = 1'b0;
    is_mem  = 1'b0;
    if (is_full) begin
      is_flow = (major == 7'h6f) || (major == 7'h67) || (major == 7'h63) ||
                ((major == 7'h0b) && (insn[31:25] == 7'h02));
      is_mem  = (major == 7'h03) || (major == 7'h23);
    end else begin
      case (insn[1:0])
        2'b00: is_mem  = (c_f3 == 3'b010) || (c_f3 == 3'b110);
        2'b01: is_flow = (c_f3 == 3'b001) || (c_f3 == 3'b101) ||
                         (c_f3 == 3'b110) || (c_f3 == 3'b111);
        2'b10: begin
          is_mem  = (c_f3 == 3'b010) || (c_f3 == 3'b110);
          is_flow = (c_f3 == 3'b100) && (insn[6:2] == 5'd0) && (insn[11:7] != 5'd0);
        end
        default: begin
          is_flow = 1'b0;
          is_mem  = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tpr_pc_state.sv
`timescale 1ns/1ps
// Tracked PC, sync flag and previous interrupt bit.
module tpr_pc_state #(
  parameter int          PC_W   = 32,
  parameter logic [31:0] IRQ_PC = 32'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            word_irq,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_sync,
  output logic [PC_W-1:0] pc_q,
  output logic            sync_q,
  output logic [PC_W-1:0] eff_pc,
  output logic            eff_sync
);
  logic            irq_q;
  logic            irq_rise;
  logic [PC_W-1:0] pc_d;
  logic            sync_d;
  logic            irq_d;
  logic            st_en;

  always_comb begin
    irq_rise = word_irq & ~irq_q;
    eff_pc   = irq_rise ? PC_W'(IRQ_PC) : pc_q;
    eff_sync = sync_q | irq_rise;
    st_en    = upd_en | accept;
    irq_d    = accept ? word_irq : irq_q;
    if (upd_en) begin
      pc_d   = upd_pc;
      sync_d = upd_sync;
    end else begin
      pc_d   = eff_pc;
      sync_d = eff_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      sync_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (st_en) begin
      pc_q   <= pc_d;
      sync_q <= sync_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/trace_pc_rebuild.sv
`timescale 1ns/1ps
module trace_pc_rebuild
  import trace_pc_rebuild_pkg::*;
#(
  parameter int          PC_W   = 32,
  parameter int          ILEN   = 32,
  parameter logic [31:0] IRQ_PC = 32'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W+3:0]   in_word,
  output logic              imem_req,
  output logic [PC_W-1:0]   imem_addr,
  input  logic              imem_rsp_valid,
  input  logic              imem_hit,
  input  logic [ILEN-1:0]   imem_insn,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_pc,
  output logic [1:0]        out_kind,
  output logic              out_irq,
  output logic              out_synced,
  output logic              out_class_err,
  output logic              out_miss
);
  localparam int IRQ_BIT  = PC_W + 3;
  localparam int ADDR_BIT = PC_W + 1;
  localparam int BR_BIT   = PC_W;
  localparam logic [PC_W-1:0] STEP_FULL = PC_W'(4);
  localparam logic [PC_W-1:0] STEP_HALF = PC_W'(2);

  seq_state_e      st_q, st_d;
  entry_kind_e     w_kind, hold_kind;
  logic            hold_irq;
  logic [PC_W-1:0] hold_pay;
  logic            hold_en;
  logic            accept;

  logic [PC_W-1:0] pc_q, eff_pc, upd_pc;
  logic            sync_q, eff_sync, upd_en, upd_sync;
  logic            is_flow, is_mem, is_full;

  logic            beat_en;
  logic [PC_W-1:0] b_pc;
  entry_kind_e     b_kind;
  logic            b_irq, b_sync, b_err, b_miss;

  tpr_pc_state #(.PC_W(PC_W), .IRQ_PC(IRQ_PC)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .word_irq (in_word[IRQ_BIT]),
    .upd_en   (upd_en),
    .upd_pc   (upd_pc),
    .upd_sync (upd_sync),
    .pc_q     (pc_q),
    .sync_q   (sync_q),
    .eff_pc   (eff_pc),
    .eff_sync (eff_sync)
  );

  tpr_insn_class #(.ILEN(ILEN)) u_class (
    .insn    (imem_insn),
    .is_flow (is_flow),
    .is_mem  (is_mem),
    .is_full (is_full)
  );

  assign in_ready  = (st_q == ST_IDLE);
  assign imem_req  = (st_q == ST_LOOK);
  assign imem_addr = pc_q;
  assign accept    = in_valid & in_ready;

  // Branch bit outranks address bit.
  always_comb begin
    if (in_word[BR_BIT])        w_kind = KIND_BRANCH;
    else if (in_word[ADDR_BIT]) w_kind = KIND_ADDR;
    else                        w_kind = KIND_RESULT;
  end

  always_comb begin
    st_d     = st_q;
    hold_en  = 1'b0;
    beat_en  = 1'b0;
    b_pc     = '0;
    b_kind   = w_kind;
    b_irq    = in_word[IRQ_BIT];
    b_sync   = 1'b0;
    b_err    = 1'b0;
    b_miss   = 1'b0;
    upd_en   = 1'b0;
    upd_pc   = pc_q;
    upd_sync = sync_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (eff_sync) begin
            st_d    = ST_LOOK;
            hold_en = 1'b1;
          end else begin
            beat_en = 1'b1;
            if (w_kind == KIND_BRANCH) begin
              upd_en   = 1'b1;
              upd_pc   = {in_word[PC_W-1:1], 1'b0};
              upd_sync = 1'b1;
            end
          end
        end
      end
      ST_LOOK: begin
        if (imem_rsp_valid) begin
          st_d    = ST_IDLE;
          beat_en = 1'b1;
          b_pc    = pc_q;
          b_kind  = hold_kind;
          b_irq   = hold_irq;
          b_sync  = 1'b1;
          upd_en  = 1'b1;
          if (imem_hit) begin
            b_err    = ((hold_kind == KIND_BRANCH) & ~is_flow) |
                       ((hold_kind == KIND_ADDR) & ~is_mem);
            upd_sync = 1'b1;
            case (hold_kind)
              KIND_BRANCH: upd_pc = {hold_pay[PC_W-1:1], 1'b0};
              KIND_ADDR:   upd_pc = pc_q;
              default:     upd_pc = pc_q + (is_full ? STEP_FULL : STEP_HALF);
            endcase
          end else begin
            b_miss   = 1'b1;
            upd_sync = (hold_kind == KIND_BRANCH);
            upd_pc   = (hold_kind == KIND_BRANCH) ? {hold_pay[PC_W-1:1], 1'b0} : pc_q;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      hold_kind <= KIND_RESULT;
      hold_irq  <= 1'b0;
      hold_pay  <= '0;
    end else begin
      st_q <= st_d;
      if (hold_en) begin
        hold_kind <= w_kind;
        hold_irq  <= in_word[IRQ_BIT];
        hold_pay  <= in_word[PC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_pc        <= '0;
      out_kind      <= 2'b00;
      out_irq       <= 1'b0;
      out_synced    <= 1'b0;
      out_class_err <= 1'b0;
      out_miss      <= 1'b0;
    end else begin
      out_valid <= beat_en;
      if (beat_en) begin
        out_pc        <= b_pc;
        out_kind      <= b_kind;
        out_irq       <= b_irq;
        out_synced    <= b_sync;
        out_class_err <= b_err;
        out_miss      <= b_miss;
      end
    end
  end
endmodule

// File: rtl/trace_pc_rebuild_chk.sv
`timescale 1ns/1ps
module trace_pc_rebuild_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            imem_req,
  input logic [PC_W-1:0] imem_addr,
  input logic            imem_rsp_valid,
  input logic            out_valid,
  input logic [1:0]      out_kind,
  input logic            out_synced,
  input logic            out_class_err,
  input logic            out_miss
);
  AST_STALL_ON_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> !in_ready); // R4

  AST_LOOKUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && !imem_rsp_valid) |=> (imem_req && $stable(imem_addr))); // R4

  AST_UNSYNC_BEAT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_synced) |-> (!out_class_err && !out_miss)); // R2

  AST_MISS_NO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> !out_class_err); // R11

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind != 2'b11)); // R12

  AST_BEAT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past((in_valid && in_ready) || (imem_req && imem_rsp_valid))); // R13
endmodule

bind trace_pc_rebuild trace_pc_rebuild_chk #(.PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .imem_req       (imem_req),
  .imem_addr      (imem_addr),
  .imem_rsp_valid (imem_rsp_valid),
  .out_valid      (out_valid),
  .out_kind       (out_kind),
  .out_synced     (out_synced),
  .out_class_err  (out_class_err),
  .out_miss       (out_miss)
);

// File: tb/trace_pc_rebuild_tb.sv
`timescale 1ns/1ps
module trace_pc_rebuild_tb;
  typedef struct packed {
    logic [31:0] pc;
    logic [1:0]  kind;
    logic        irq;
    logic        sync;
    logic        err;
    logic        miss;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_word = '0;
  logic        imem_req;
  logic [31:0] imem_addr;
  logic        imem_rsp_valid = 1'b0;
  logic        imem_hit = 1'b0;
  logic [31:0] imem_insn = '0;
  logic        out_valid;
  logic [31:0] out_pc;
  logic [1:0]  out_kind;
  logic        out_irq, out_synced, out_class_err, out_miss;

  int          n_checks = 0;
  int          n_fail = 0;
  int          cycles = 0;
  int          mem_lat = 0;
  int          lat_cnt = 0;
  bit          done = 1'b0;

  logic [31:0] imem_mem [logic [31:0]];
  beat_t       exp_q [$];
  logic [31:0] look_q [$];
  longint      m_pc = -1;
  bit          m_last_irq = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  trace_pc_rebuild u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rsp_valid(imem_rsp_valid),
    .imem_hit(imem_hit), .imem_insn(imem_insn), .out_valid(out_valid), .out_pc(out_pc),
    .out_kind(out_kind), .out_irq(out_irq), .out_synced(out_synced),
    .out_class_err(out_class_err), .out_miss(out_miss)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit b_flow(input logic [31:0] op);
    if (op[1:0] == 2'b11)
      return (op[6:0] inside {7'h6f, 7'h67, 7'h63}) || (op[6:0] == 7'h0b && op[31:25] == 7'h02);
    casez ({op[15:13], op[1:0]})
      5'b001_01, 5'b101_01, 5'b110_01, 5'b111_01: return 1'b1;
      5'b100_10: return (op[6:2] == 5'd0) && (op[11:7] != 5'd0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit b_mem(input logic [31:0] op);
    if (op[1:0] == 2'b11) return op[6:0] inside {7'h03, 7'h23};
    return {op[15:13], op[1:0]} inside {5'b010_00, 5'b110_00, 5'b010_10, 5'b110_10};
  endfunction

  // Behavioural reference: decide the beat of one accepted word.
  function automatic void model(input logic [35:0] w);
    beat_t b;
    logic [31:0] pay;
    logic [31:0] op;
    bit irq, is_br, is_ad;
    irq = w[35];
    is_br = w[32];
    is_ad = w[33] && !w[32];
    pay = w[31:0];
    if (irq && !m_last_irq) m_pc = 32'h10;
    m_last_irq = irq;
    b = '0;
    b.kind = is_br ? 2'b10 : (is_ad ? 2'b01 : 2'b00);
    b.irq = irq;
    if (m_pc < 0) begin
      if (is_br) m_pc = {pay[31:1], 1'b0};
    end else begin
      b.pc = m_pc[31:0];
      b.sync = 1'b1;
      look_q.push_back(m_pc[31:0]);
      if (imem_mem.exists(m_pc[31:0])) begin
        op = imem_mem[m_pc[31:0]];
        b.err = (is_br && !b_flow(op)) || (is_ad && !b_mem(op));
        if (!is_ad) m_pc = m_pc + ((op[1:0] == 2'b11) ? 4 : 2);
        if (is_br) m_pc = {pay[31:1], 1'b0};
      end else begin
        b.miss = 1'b1;
        m_pc = is_br ? longint'({pay[31:1], 1'b0}) : -1;
      end
    end
    exp_q.push_back(b);
  endfunction

  function automatic logic [35:0] mk(input bit irq, input bit ad, input bit br, input logic [31:0] pay);
    return {irq, 1'b0, ad, br, pay};
  endfunction

  // Called just after a falling edge.
  task automatic send(input logic [35:0] w);
    in_valid = 1'b1;
    in_word = w;
    while (!in_ready) @(negedge clk);
    model(w);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Instruction memory with adjustable latency.
  always @(negedge clk) begin
    imem_rsp_valid = 1'b0;
    if (rst_n && imem_req) begin
      if (lat_cnt >= mem_lat) begin
        lat_cnt = 0;
        chk(in_ready == 1'b0, "R4 stall during lookup", 64'(in_ready), 64'd0);
        if (look_q.size() == 0) begin
          chk(1'b0, "R2 unexpected lookup", 64'(imem_addr), 64'd0);
        end else begin
          logic [31:0] ea;
          ea = look_q.pop_front();
          chk(imem_addr == ea, "R4 lookup address", 64'(imem_addr), 64'(ea));
        end
        imem_rsp_valid = 1'b1;
        imem_hit = imem_mem.exists(imem_addr);
        imem_insn = imem_hit ? imem_mem[imem_addr] : 32'h0;
      end else begin
        lat_cnt++;
      end
    end
  end

  // Compare each output beat with the model.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R13 beat without entry", 64'(out_pc), 64'd0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(out_pc == e.pc, "R5 R6 R7 R8 pc", 64'(out_pc), 64'(e.pc));
        chk(out_kind == e.kind && out_irq == e.irq, "R12 kind/irq",
            64'({out_kind, out_irq}), 64'({e.kind, e.irq}));
        chk(out_synced == e.sync, "R2 R3 sync", 64'(out_synced), 64'(e.sync));
        chk(out_class_err == e.err, "R9 R10 class error", 64'(out_class_err), 64'(e.err));
        chk(out_miss == e.miss, "R11 miss", 64'(out_miss), 64'(e.miss));
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 64'(cycles), 64'd100000);
      summary();
    end
  end

  initial begin
    imem_mem[32'h100] = 32'h00000013; // addi
    imem_mem[32'h104] = 32'h00000505; // compressed add-immediate
    imem_mem[32'h106] = 32'h0002a283; // lw
    imem_mem[32'h10a] = 32'h008000ef; // jal
    imem_mem[32'h200] = 32'h00004108; // compressed lw
    imem_mem[32'h202] = 32'h0000a001; // compressed j
    imem_mem[32'h10]  = 32'h00a12023; // sw
    imem_mem[32'h14]  = 32'h0400000b; // interrupt return

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready in reset", 64'(in_ready), 64'd1);
    chk(imem_req == 1'b0, "R1 imem_req in reset", 64'(imem_req), 64'd0);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1 && imem_req == 1'b0 && out_valid == 1'b0, "R1 idle after reset",
        64'({in_ready, imem_req, out_valid}), 64'b100);

    // R2 unsynchronised entries, R3 branch resync
    send(mk(0, 0, 0, 32'h1234));
    send(mk(0, 1, 0, 32'h8000));
    send(mk(0, 0, 1, 32'h100));
    // R5 steps, R6 hold, R7 reload (zero latency)
    send(mk(0, 0, 0, 32'h1));
    send(mk(0, 0, 0, 32'h2));
    send(mk(0, 1, 0, 32'h9000));
    send(mk(0, 0, 0, 32'h3));
    send(mk(0, 0, 1, 32'h200));
    // same with latency
    mem_lat = 2;
    send(mk(0, 1, 0, 32'h9004));
    send(mk(0, 0, 0, 32'h4));
    send(mk(0, 0, 1, 32'h100));
    // R9 R10 class errors
    send(mk(0, 0, 1, 32'h104));
    send(mk(0, 1, 0, 32'h9008));
    send(mk(0, 0, 0, 32'h5));
    // R8 interrupt entry and return
    mem_lat = 1;
    send(mk(1, 1, 0, 32'h9010));
    send(mk(1, 0, 0, 32'h6));
    send(mk(1, 0, 1, 32'h106));
    send(mk(0, 0, 0, 32'h7));
    // R11 miss on result, then resync; branch miss keeps sync
    send(mk(0, 0, 1, 32'h300));
    send(mk(0, 0, 0, 32'h8));
    send(mk(0, 0, 0, 32'h9));
    send(mk(0, 0, 1, 32'h100));
    send(mk(0, 0, 1, 32'h400));
    send(mk(0, 0, 1, 32'h201));
    send(mk(0, 0, 0, 32'ha));
    // R12 both kind bits set acts as branch
    mem_lat = 0;
    send(mk(0, 1, 1, 32'h100));
    // R8 interrupt rise while unsynchronised
    send(mk(0, 0, 1, 32'h300));
    send(mk(0, 0, 0, 32'hb));
    send(mk(1, 0, 0, 32'hc));
    send(mk(0, 0, 0, 32'hd));

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R13 all beats delivered", 64'(exp_q.size()), 64'd0);
    chk(look_q.size() == 0, "R4 all lookups issued", 64'(look_q.size()), 64'd0);
    done = 1'b1;
    summary();
  end
endmodule